// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises software with two escalating stages. Once running, a counter advances every clock. When the count reaches the interval picked by a two-bit mode field, the block raises a sticky interrupt flag and opens a fixed grace window of 512 clocks. If software restarts the counter before that window closes, nothing further happens. If it does not, and the reset function is enabled, the block emits a one-cycle system reset pulse and records a sticky reset-cause flag.

Software reaches the block through a single byte-wide control register. A write strobe carries the new field values. The run, mode, reset-enable, interrupt-flag and restart fields change only when an external protection-open qualifier is high in the same cycle. The reset-cause flag can be cleared without that qualifier.

A watchdog reset restarts the count and leaves the watchdog running. Only the power-on reset stops it. A test parameter shortens the intervals so that simulation stays short.

Top module: `wdt_two_stage`

## Requirements
- R1: After power-on reset (rstN low), the control register reads 0x00, irqReq is 0 and sysRstPulse is 0. The register layout is: bit 6 run, bits 5:4 mode, bit 3 interrupt flag, bit 2 reset-cause flag, bit 1 reset enable, bit 0 restart. Bit 7 reads 0.
- R2: The interrupt flag (bit 3) becomes 1 exactly T clocks after the write edge that starts or restarts the count, where T = 2^(17+3*mode-TH_SHIFT). Modes 00, 01, 10 and 11 therefore give 2^17, 2^20, 2^23 and 2^26 clocks when TH_SHIFT is 0.
- R3: With reset enable set, sysRstPulse is high for exactly one cycle, 512 clocks after the interrupt flag was set.
- R4: With reset enable cleared, no reset pulse is issued and the reset-cause flag is not set. The counter still runs and the interrupt flag still sets at timeout.
- R5: A protected write with bit 0 set clears and restarts the count, including a grace window already in progress. This also holds in the very cycle the grace window would expire. Bit 0 reads 1 for one cycle, then 0.
- R6: irqReq equals the interrupt flag ANDed with the irqEnable input.
- R7: The interrupt flag is cleared by a protected write with bit 3 = 0 and by a watchdog reset. A timeout in the same cycle as a clearing write leaves the flag set.
- R8: A watchdog reset sets the reset-cause flag (bit 2), keeps run, mode and reset enable, and restarts the count, so the next interrupt flag follows T clocks later. The reset-cause flag stays set until a write with bit 2 = 0 clears it; this write does not need the protection qualifier.
- R9: A write with accessOpen low leaves the run, mode, reset-enable, interrupt-flag and restart fields unchanged.
- R10: While run is 0, both counters hold at zero and no flag or reset is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low |
| wrEn | input | 1 | Control register write strobe |
| wrData | input | 8 | Write data for the control fields |
| accessOpen | input | 1 | Protection-open qualifier for guarded fields |
| irqEnable | input | 1 | External watchdog interrupt enable |
| ctrlRd | output | 8 | Control register readback |
| irqReq | output | 1 | Interrupt request |
| sysRstPulse | output | 1 | One-cycle system reset request |

## Verification
Two pairs of events can fall on the same clock edge. The first pair is the timeout and a software write that clears the interrupt flag. The bench places that write exactly on the timeout edge and expects the flag to survive. The second pair is the grace window's expiry and a restart write. The bench lands a restart on the expiry edge and expects no reset pulse, with the next interrupt a full interval later. Every flag rise and reset pulse is matched by cycle number against a queue of predicted events.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Control -> datapath strobes
  typedef struct packed {
    logic       runEn;
    logic       restart;
    logic [1:0] mode;
  } wdStrobe_t;

  // Datapath -> control events
  typedef struct packed {
    logic timeoutHit;
    logic graceDone;
  } wdEvent_t;

  localparam int BIT_RESTART = 0;
  localparam int BIT_RSTEN   = 1;
  localparam int BIT_CAUSE   = 2;
  localparam int BIT_IRQF    = 3;
  localparam int BIT_MODE_LO = 4;
  localparam int BIT_RUN     = 6;

endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W       = 26,
  parameter int TH_SHIFT    = 0,
  parameter int GRACE_CLKS  = 512
) (
  input  logic      clk,
  input  logic      rstN,
  input  wdStrobe_t strobes,
  output wdEvent_t  events
);

  localparam int GRACE_W = $clog2(GRACE_CLKS);
  localparam int NUM_MODES = 4;

  logic [CNT_W-1:0]   mainCnt;
  logic [GRACE_W-1:0] graceCnt;
  logic               graceActive;
  logic [CNT_W-1:0]   thrMinusOne [NUM_MODES];
  logic               active;

  // One terminal value per mode, each interval 8x the previous
  for (genvar g = 0; g < NUM_MODES; g++) begin : g_thr
    localparam longint THR = longint'(1) << (17 + 3*g - TH_SHIFT);
    assign thrMinusOne[g] = CNT_W'(THR - 1);
  end

  assign active = strobes.runEn && !strobes.restart;

  assign events.timeoutHit = active && !graceActive &&
                             (mainCnt >= thrMinusOne[strobes.mode]);
  assign events.graceDone  = active && graceActive &&
                             (graceCnt == GRACE_W'(GRACE_CLKS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainCnt     <= '0;
      graceCnt    <= '0;
      graceActive <= 1'b0;
    end else if (!active || events.graceDone) begin
      mainCnt     <= '0;
      graceCnt    <= '0;
      graceActive <= 1'b0;
    end else if (graceActive) begin
      graceCnt    <= graceCnt + 1'b1;
    end else if (events.timeoutHit) begin
      graceActive <= 1'b1;
      graceCnt    <= '0;
    end else begin
      mainCnt     <= mainCnt + 1'b1;
    end
  end

  // R10: stopped watchdog holds its counters at zero
  assert_stopped_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.runEn) |=> (mainCnt == '0 && !graceActive));

  // R3: main count freezes while the grace window runs
  assert_hold_in_grace_R3: assert property (@(posedge clk) disable iff (!rstN)
    (graceActive && active && !events.graceDone) |=> $stable(mainCnt));

  // R3: grace count advances by one each cycle of the window
  assert_grace_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (graceActive && active && !events.graceDone) |=>
      (graceCnt == $past(graceCnt) + 1'b1));

endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       accessOpen,
  input  logic       irqEnable,
  input  wdEvent_t   events,
  output wdStrobe_t  strobes,
  output logic [7:0] ctrlRd,
  output logic       irqReq,
  output logic       sysRstPulse
);

  logic       protWr;
  logic       restartReq;
  logic       wdReset;
  logic       runBit;
  logic [1:0] modeBits;
  logic       rstEnBit;
  logic       restartBit;
  logic       irqFlag;
  logic       causeFlag;

  assign protWr     = wrEn && accessOpen;
  assign restartReq = protWr && wrData[BIT_RESTART];
  assign wdReset    = events.graceDone && rstEnBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit     <= 1'b0;
      modeBits   <= 2'b00;
      rstEnBit   <= 1'b0;
      restartBit <= 1'b0;
    end else begin
      restartBit <= restartReq;
      if (protWr) begin
        runBit   <= wrData[BIT_RUN];
        modeBits <= wrData[BIT_MODE_LO +: 2];
        rstEnBit <= wrData[BIT_RSTEN];
      end
    end
  end

  // Interrupt flag: hardware set wins over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                irqFlag <= 1'b0;
    else if (events.timeoutHit)               irqFlag <= 1'b1;
    else if (wdReset)                         irqFlag <= 1'b0;
    else if (protWr && !wrData[BIT_IRQF])     irqFlag <= 1'b0;
  end

  // Reset-cause flag: clearable without the protection qualifier
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                causeFlag <= 1'b0;
    else if (wdReset)                         causeFlag <= 1'b1;
    else if (wrEn && !wrData[BIT_CAUSE])      causeFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sysRstPulse <= 1'b0;
    else       sysRstPulse <= wdReset;
  end

  always_comb begin
    strobes.runEn   = runBit;
    strobes.restart = restartReq;
    strobes.mode    = modeBits;
  end

  assign ctrlRd = {1'b0, runBit, modeBits, irqFlag, causeFlag, rstEnBit, restartBit};
  assign irqReq = irqFlag && irqEnable;

  // R3: reset request lasts one cycle
  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    sysRstPulse |=> !sysRstPulse);

  // R4: disabled reset function never pulses
  assert_no_pulse_disabled_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!rstEnBit) |=> !sysRstPulse);

  // R5: restart bit self-clears unless re-written
  assert_restart_selfclear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (restartBit && !restartReq) |=> !restartBit);

  // R8: cause flag rises only together with a reset pulse
  assert_cause_with_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(causeFlag) |-> sysRstPulse);

  // R9: guarded fields hold without an open protection window
  assert_locked_fields_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!protWr) |=> ($stable(runBit) && $stable(modeBits) && $stable(rstEnBit)));

endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int CNT_W      = 26,
  parameter int TH_SHIFT   = 0,
  parameter int GRACE_CLKS = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       accessOpen,
  input  logic       irqEnable,
  output logic [7:0] ctrlRd,
  output logic       irqReq,
  output logic       sysRstPulse
);

  wdStrobe_t strobes;
  wdEvent_t  events;

  wdt_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .accessOpen (accessOpen),
    .irqEnable  (irqEnable),
    .events     (events),
    .strobes    (strobes),
    .ctrlRd     (ctrlRd),
    .irqReq     (irqReq),
    .sysRstPulse(sysRstPulse)
  );

  wdt_datapath #(
    .CNT_W     (CNT_W),
    .TH_SHIFT  (TH_SHIFT),
    .GRACE_CLKS(GRACE_CLKS)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .events (events)
  );

endmodule

// File: tb/sim_wdt_two_stage.sv
module sim_wdt_two_stage;

  localparam int CLK_PERIOD = 10;
  localparam int SHIFT      = 12;
  localparam int GRACE      = 512;

  typedef struct {
    int    kind;   // 1 = interrupt flag rise, 2 = reset pulse
    int    cyc;
    string tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       accessOpen = 1'b0;
  logic       irqEnable = 1'b1;
  logic [7:0] ctrlRd;
  logic       irqReq;
  logic       sysRstPulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lastEdge = 0;
  bit prevFlag = 1'b0;
  bit done = 1'b0;
  expItem_t expQ[$];

  wdt_two_stage #(.TH_SHIFT(SHIFT), .GRACE_CLKS(GRACE)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .accessOpen(accessOpen), .irqEnable(irqEnable),
    .ctrlRd(ctrlRd), .irqReq(irqReq), .sysRstPulse(sysRstPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int thrOf(int m);
    return 1 << (17 + 3*m - SHIFT);
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic push(int kind, int c, string tag);
    expItem_t it;
    it.kind = kind; it.cyc = c; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic waitUntil(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic writeReg(logic [7:0] d, logic open);
    @(negedge clk);
    wrEn = 1'b1; wrData = d; accessOpen = open;
    @(negedge clk);
    wrEn = 1'b0; accessOpen = 1'b0;
    lastEdge = cyc;
  endtask

  task automatic writeAt(logic [7:0] d, logic open, int target);
    waitUntil(target - 1);
    wrEn = 1'b1; wrData = d; accessOpen = open;
    @(negedge clk);
    wrEn = 1'b0; accessOpen = 1'b0;
    lastEdge = cyc;
  endtask

  task automatic matchEvent(int kind);
    expItem_t it;
    if (expQ.size() == 0) begin
      check(1'b0, kind == 1 ? "R2/R10 unexpected flag" : "R4/R10 unexpected pulse", cyc, -1);
    end else begin
      it = expQ.pop_front();
      check(it.kind == kind && it.cyc == cyc, it.tag, cyc, it.cyc);
    end
  endtask

  // Monitor: every flag rise and reset pulse must match the queue head
  always @(negedge clk) begin
    if (rstN) begin
      if (ctrlRd[3] && !prevFlag) matchEvent(1);
      if (sysRstPulse) matchEvent(2);
      prevFlag = ctrlRd[3];
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int e, p, r, q, d, m0, s, s2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ctrlRd == 8'h00, "R1 ctrl", ctrlRd, 8'h00);
    check(irqReq == 1'b0, "R1 irq", irqReq, 0);
    check(sysRstPulse == 1'b0, "R1 pulse", sysRstPulse, 0);
    repeat (100) @(negedge clk);   // R10: stopped, no events expected

    // R9: locked write has no effect
    writeReg(8'h42, 1'b0);
    check(ctrlRd == 8'h00, "R9 locked write", ctrlRd, 8'h00);
    repeat (100) @(negedge clk);

    // R2/R3: start, mode 0, reset enabled
    writeReg(8'h42, 1'b1);
    e = lastEdge;
    check(ctrlRd == 8'h42, "R9 open write", ctrlRd, 8'h42);
    push(1, e + thrOf(0), "R2 mode0 timeout");
    push(2, e + thrOf(0) + GRACE, "R3 grace gap");
    waitUntil(e + thrOf(0) + 1);
    check(irqReq == 1'b1, "R6 irq enabled", irqReq, 1);
    irqEnable = 1'b0;
    @(negedge clk);
    check(irqReq == 1'b0 && ctrlRd[3], "R6 irq masked", irqReq, 0);
    irqEnable = 1'b1;
    p = e + thrOf(0) + GRACE;
    waitUntil(p + 1);
    check(ctrlRd == 8'h46, "R8 after reset", ctrlRd, 8'h46);
    push(1, p + thrOf(0), "R8 restart after reset");

    // R5: restart inside grace window, also clears flag (R7)
    waitUntil(p + thrOf(0) + 100);
    writeReg(8'h47, 1'b1);
    r = lastEdge;
    check(ctrlRd[3] == 1'b0, "R7 software clear", ctrlRd[3], 0);
    @(negedge clk);
    check(ctrlRd[0] == 1'b0, "R5 self clear", ctrlRd[0], 0);
    push(1, r + thrOf(0), "R5 restart timing");
    push(2, r + thrOf(0) + GRACE, "R5 grace after restart");
    q = r + thrOf(0) + GRACE;
    waitUntil(q + 1);

    // R8: cause flag cleared by a locked write, other fields kept
    writeReg(8'h00, 1'b0);
    check(ctrlRd == 8'h42, "R8 cause clear", ctrlRd, 8'h42);

    // R4: reset disabled, timer keeps running
    writeReg(8'h41, 1'b1);
    d = lastEdge;
    push(1, d + thrOf(0), "R4 flag still sets");
    waitUntil(d + thrOf(0) + GRACE + 16);
    check(ctrlRd == 8'h48, "R4 no cause", ctrlRd, 8'h48);

    // R2: remaining modes
    for (int m = 1; m < 4; m++) begin
      writeReg(8'h41 | 8'(m << 4), 1'b1);
      m0 = lastEdge;
      check(ctrlRd[5:4] == 2'(m), "R2 mode readback", ctrlRd[5:4], m);
      push(1, m0 + thrOf(m), "R2 mode timeout");
      waitUntil(m0 + thrOf(m) + 1);
    end

    // R7: clear write on the timeout edge loses to the set
    writeReg(8'h41, 1'b1);
    s = lastEdge;
    push(1, s + thrOf(0), "R7 set wins");
    writeAt(8'h40, 1'b1, s + thrOf(0));
    check(ctrlRd[3] == 1'b1, "R7 same-cycle clear", ctrlRd[3], 1);

    // R5: restart on the grace-expiry edge suppresses the reset
    writeReg(8'h43, 1'b1);
    s2 = lastEdge;
    push(1, s2 + thrOf(0), "R5 race timeout");
    writeAt(8'h43, 1'b1, s2 + thrOf(0) + GRACE);
    push(1, s2 + 2*thrOf(0) + GRACE, "R5 race restart");
    waitUntil(s2 + 2*thrOf(0) + GRACE + 20);
    check(ctrlRd[2] == 1'b0, "R5 race no cause", ctrlRd[2], 0);

    // R10: stop and wait well beyond any interval
    writeReg(8'h00, 1'b1);
    check(ctrlRd == 8'h00, "R10 stopped", ctrlRd, 8'h00);
    repeat (1000) @(negedge clk);
    check(ctrlRd == 8'h00 && !sysRstPulse, "R10 idle", ctrlRd, 8'h00);
    check(expQ.size() == 0, "R2 pending events", expQ.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule